// File: doc/BRIEF.md
# SPI-Controlled UART Command Interface

This block is the device-side command logic of a UART that a host drives over SPI. The host lowers an active-low select, then exchanges a 16-bit word, most significant bit first. Data goes both ways at the same time. The top two bits the host sends choose one of four operations: store the line configuration, read it back, queue a byte for transmission, or collect a received byte. Every reply carries two live status flags in its top bits, so any exchange also works as a status poll. A received byte is available (R), or the transmit holding register can accept a byte (T).

The UART datapath sits outside the block. Toward the transmitter, the block presents a 9-bit character (8 data bits plus a parity or ninth bit) on a valid/ready stream. The transmit side is back-pressured: `tx_valid` stays high and `tx_data` stays unchanged until the cycle in which `tx_ready` is high. Only then does the holding register empty. While it is full, T reads 0 and further data writes do not overwrite it.

The receiver pushes characters with a plain valid strobe and cannot be stalled. A character that arrives while the receive FIFO is at its limit is dropped. The stored configuration and a baud multiplier decoded from it are driven out as plain control outputs, and so are the RTS level and the CTS input.

The SPI pins are sampled in the system clock domain, so SCLK must run well below the system clock. Every register update happens on the rising edge of the select, and only when the frame had exactly 16 clocks.

Top module: `spi_uart_cmd`

## Requirements
- R1: While `spi_cs_n` is low, the block shifts `spi_mosi` in on each rising SCLK edge, MSB first. It presents reply bit 15 on `spi_miso` from the select falling edge and advances `spi_miso` one bit after each falling SCLK edge. `spi_miso` is 0 while the select is high.
- R2: In every reply, bit 15 is 1 when the receive FIFO held a character at the select falling edge. Bit 14 is 1 when the transmit holding register was empty at that edge.
- R3: The opcode is incoming bits 15:14. Opcode 2'b11 stores bits 13:0 into `cfg_word` at the select rising edge, and reply bits 13:0 are 0. Configuration bit 13 enables the deep FIFO, bit 12 is shutdown, and bits 3:0 are the baud code.
- R4: Opcode 2'b01 returns the stored configuration in reply bits 13:0.
- R5: Opcode 2'b10 (data write) loads {bit 8, bits 7:0} into the transmit holding register and raises `tx_valid`, but only when bit 10 is 0 and the register is empty. Otherwise the character is discarded.
- R6: Once raised, `tx_valid` and `tx_data` hold until a cycle with `tx_ready` high, after which the register is empty and T reads 1 again.
- R7: A data write sets `rts_n` to the inverse of its bit 9 at the select rising edge, whatever bit 10 holds.
- R8: Opcodes 2'b00 and 2'b10 reply with a data word. Bits 8:0 hold the oldest received character and bit 9 is the inverse of `cts_n`. Bit 10 is that character's framing error when shutdown is 0, or `rx_active` when shutdown is 1. If R was set, the character is removed at the select rising edge. If R was 0, bits 8:0 are 0, and so is bit 10 outside shutdown.
- R9: The receive FIFO keeps characters in arrival order. Its limit is 8 entries when configuration bit 13 is 1 and 1 entry when it is 0. A character that arrives at the limit is dropped.
- R10: A frame with anything other than exactly 16 SCLK rising edges changes no register and removes no character.
- R11: `baud_mult` is 1<<c for baud code c from 0 to 7, and 3<<(c-8) for c from 8 to 15. This gives the bit period in units of 16 oscillator cycles; for example, code 9 gives 6 and code 15 gives 384.
- R12: After reset, `cfg_word` is 0, `rts_n` is 1, `tx_valid` is 0, the receive FIFO is empty and `spi_miso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock from host, idles low |
| spi_cs_n | input | 1 | SPI select, active low |
| spi_mosi | input | 1 | Host-to-device serial data |
| spi_miso | output | 1 | Device-to-host serial data |
| tx_valid | output | 1 | Transmit character available |
| tx_ready | input | 1 | Transmitter accepts the character |
| tx_data | output | 9 | Transmit character, bit 8 is parity/ninth bit |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 9 | Received character, bit 8 is parity/ninth bit |
| rx_ferr | input | 1 | Framing error of the received character |
| rx_active | input | 1 | Receiver line activity indication |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |
| cfg_word | output | 14 | Stored line configuration |
| baud_mult | output | 9 | Bit period in 16-oscillator-cycle units |

## Verification
Assertions check four things on every cycle. The transmit character stays held under back-pressure, the FIFO never passes its limit, a character is removed only when one is present, and the configuration and transmit register change only after a complete frame. `spi_miso` is also checked to move only after a select or SCLK falling edge. Only the bench scenarios can show the content of the replies: status flags, read-back of the configuration, arrival order, the 1-entry versus 8-entry limit, the meaning of bit 10 in shutdown, the baud decode, and the rejection of short and long frames.

// File: rtl/suc_pkg.sv
package suc_pkg;
  localparam int FRAME_W = 16;
  localparam int OP_W    = 2;
  localparam int CFG_W   = FRAME_W - OP_W;
  localparam int CHAR_W  = 9;
  localparam int BAUD_W  = 4;
  localparam int MULT_W  = 9;

  localparam int CFG_DEEP_BIT = 13;
  localparam int CFG_SHDN_BIT = 12;
  localparam int DW_TXOFF_BIT = 10;
  localparam int DW_RTS_BIT   = 9;

  typedef enum logic [OP_W-1:0] {
    OP_RD_DATA = 2'b00,
    OP_RD_CFG  = 2'b01,
    OP_WR_DATA = 2'b10,
    OP_WR_CFG  = 2'b11
  } op_e;

  typedef struct packed {
    logic              ferr;
    logic [CHAR_W-1:0] ch;
  } rx_ent_t;
endpackage

// File: rtl/suc_baud_map.sv
module suc_baud_map
  import suc_pkg::*;
(
  input  logic [BAUD_W-1:0] code,
  output logic [MULT_W-1:0] mult
);
  localparam int N_CODES = 1 << BAUD_W;
  localparam int HALF    = N_CODES / 2;

  logic [MULT_W-1:0] tbl [N_CODES];

  for (genvar g = 0; g < N_CODES; g++) begin : g_tbl
    if (g < HALF) begin : g_lo
      assign tbl[g] = MULT_W'(1 << g);
    end else begin : g_hi
      assign tbl[g] = MULT_W'(3 << (g - HALF));
    end
  end

  assign mult = tbl[code];
endmodule

// File: rtl/suc_rx_fifo.sv
module suc_rx_fifo
  import suc_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    deep,
  input  logic    push,
  input  rx_ent_t push_ent,
  input  logic    pop,
  output rx_ent_t head,
  output logic    empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  rx_ent_t       mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          at_limit, do_push, do_pop;

  assign at_limit = deep ? (cnt == CW'(DEPTH)) : (cnt != '0);
  assign do_push  = push && !at_limit;
  assign do_pop   = pop && (cnt != '0);
  assign empty    = (cnt == '0);
  assign head     = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_ent;
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH)); // R9
  AST_SHALLOW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!deep && cnt != '0 && push && !pop) |=> (cnt == $past(cnt))); // R9
  AST_EMPTY_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cnt == '0) |=> $stable(rd_ptr)); // R8
endmodule

// File: rtl/suc_spi_slave.sv
module suc_spi_slave
  import suc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sclk,
  input  logic                    cs_n,
  input  logic                    mosi,
  output logic                    miso,
  input  logic [OP_W-1:0]         stat_hi,
  output logic                    frame_start,
  output logic                    op_valid,
  output logic [OP_W-1:0]         op_code,
  input  logic [FRAME_W-OP_W-1:0] reply_lo,
  output logic                    frame_done,
  output logic                    frame_ok,
  output logic [FRAME_W-1:0]      frame_word
);
  localparam int RC_W = $clog2(FRAME_W + 2);
  localparam int FC_W = $clog2(FRAME_W);

  logic [2:0]         sync_q [SYNC_STAGES];
  logic               sclk_s, cs_s, mosi_s, sclk_d, cs_d;
  logic               sel, cs_fall, cs_rise, sck_rise, sck_fall;
  logic [RC_W-1:0]    rise_cnt;
  logic [FC_W-1:0]    fall_cnt;
  logic [FRAME_W-1:0] shift_in, next_in, reply_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= 3'b010;
    end else begin
      sync_q[0] <= {sclk, cs_n, mosi};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign {sclk_s, cs_s, mosi_s} = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end

  assign sel      = !cs_d && !cs_s;
  assign cs_fall  = cs_d && !cs_s;
  assign cs_rise  = !cs_d && cs_s;
  assign sck_rise = sel && !sclk_d && sclk_s;
  assign sck_fall = sel && sclk_d && !sclk_s;
  assign next_in  = {shift_in[FRAME_W-2:0], mosi_s};

  assign frame_start = cs_fall;
  assign op_valid    = sck_rise && (rise_cnt == RC_W'(OP_W - 1));
  assign op_code     = next_in[OP_W-1:0];
  assign frame_done  = cs_rise;
  assign frame_ok    = (rise_cnt == RC_W'(FRAME_W));
  assign frame_word  = shift_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cnt <= '0;
      fall_cnt <= '0;
      shift_in <= '0;
      reply_q  <= '0;
    end else if (cs_fall) begin
      rise_cnt <= '0;
      fall_cnt <= '0;
      reply_q  <= {stat_hi, {(FRAME_W-OP_W){1'b0}}};
    end else if (sck_rise) begin
      shift_in <= next_in;
      if (rise_cnt != '1) rise_cnt <= rise_cnt + 1'b1;
      if (op_valid) reply_q[FRAME_W-OP_W-1:0] <= reply_lo;
    end else if (sck_fall) begin
      if (fall_cnt != FC_W'(FRAME_W - 1)) fall_cnt <= fall_cnt + 1'b1;
    end
  end

  assign miso = (!cs_s && !cs_d) ? reply_q[FC_W'(FRAME_W - 1) - fall_cnt] : 1'b0;

  AST_MISO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel) && sel && !$past(sck_fall) && !$past(cs_fall)) |-> $stable(miso)); // R1
  AST_FRAME_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_fall && fall_cnt == FC_W'(FRAME_W - 1)) |=> (fall_cnt == FC_W'(FRAME_W - 1))); // R1
endmodule

// File: rtl/spi_uart_cmd.sv
module spi_uart_cmd
  import suc_pkg::*;
#(
  parameter int FIFO_DEPTH  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [CHAR_W-1:0] tx_data,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              rx_ferr,
  input  logic              rx_active,
  input  logic              cts_n,
  output logic              rts_n,
  output logic [CFG_W-1:0]  cfg_word,
  output logic [MULT_W-1:0] baud_mult
);
  logic                    frame_start, op_valid, frame_done, frame_ok;
  logic [OP_W-1:0]         op_code;
  logic [FRAME_W-OP_W-1:0] reply_lo;
  logic [FRAME_W-1:0]      frame_word;
  logic [SYNC_STAGES-1:0]  cts_sync;
  logic                    cts_on, r_snap, commit, fifo_pop, fifo_empty;
  logic                    tx_full, rts_q, bit10;
  logic [CFG_W-1:0]        cfg_q;
  logic [CHAR_W-1:0]       tx_q;
  rx_ent_t                 head;
  op_e                     cop;

  suc_spi_slave #(.SYNC_STAGES(SYNC_STAGES)) u_spi (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk        (spi_sclk),
    .cs_n        (spi_cs_n),
    .mosi        (spi_mosi),
    .miso        (spi_miso),
    .stat_hi     ({!fifo_empty, !tx_full}),
    .frame_start (frame_start),
    .op_valid    (op_valid),
    .op_code     (op_code),
    .reply_lo    (reply_lo),
    .frame_done  (frame_done),
    .frame_ok    (frame_ok),
    .frame_word  (frame_word)
  );

  suc_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .deep     (cfg_q[CFG_DEEP_BIT]),
    .push     (rx_valid),
    .push_ent ({rx_ferr, rx_data}),
    .pop      (fifo_pop),
    .head     (head),
    .empty    (fifo_empty)
  );

  suc_baud_map u_baud (
    .code (cfg_q[BAUD_W-1:0]),
    .mult (baud_mult)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cts_sync <= '1;
    else        cts_sync <= {cts_sync[SYNC_STAGES-2:0], cts_n};
  end
  assign cts_on = !cts_sync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           r_snap <= 1'b0;
    else if (frame_start) r_snap <= !fifo_empty;
  end

  assign bit10 = cfg_q[CFG_SHDN_BIT] ? rx_active : (r_snap && head.ferr);

  always_comb begin
    case (op_e'(op_code))
      OP_RD_CFG: reply_lo = cfg_q;
      OP_WR_CFG: reply_lo = '0;
      default:   reply_lo = {3'b000, bit10, cts_on, (r_snap ? head.ch : {CHAR_W{1'b0}})};
    endcase
  end

  assign commit   = frame_done && frame_ok;
  assign cop      = op_e'(frame_word[FRAME_W-1 -: OP_W]);
  assign fifo_pop = commit && r_snap && (cop == OP_RD_DATA || cop == OP_WR_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      rts_q   <= 1'b0;
      tx_full <= 1'b0;
      tx_q    <= '0;
    end else begin
      if (tx_full && tx_ready) tx_full <= 1'b0;
      if (commit && cop == OP_WR_CFG) cfg_q <= frame_word[CFG_W-1:0];
      if (commit && cop == OP_WR_DATA) begin
        rts_q <= frame_word[DW_RTS_BIT];
        if (!frame_word[DW_TXOFF_BIT] && !tx_full) begin
          tx_full <= 1'b1;
          tx_q    <= frame_word[CHAR_W-1:0];
        end
      end
    end
  end

  assign tx_valid = tx_full;
  assign tx_data  = tx_q;
  assign rts_n    = !rts_q;
  assign cfg_word = cfg_q;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R6
  AST_TX_LOAD_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(frame_done && frame_ok)); // R10
  AST_CFG_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_word) |-> $past(frame_done && frame_ok)); // R3
  AST_POP_HAS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty); // R8
endmodule

// File: tb/spi_uart_cmd_bench.sv
module spi_uart_cmd_bench;
  localparam int HP = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic       spi_miso;
  logic       tx_valid, tx_ready = 1'b0;
  logic [8:0] tx_data;
  logic       rx_valid = 1'b0, rx_ferr = 1'b0, rx_active = 1'b0, cts_n = 1'b0;
  logic [8:0] rx_data = '0;
  logic       rts_n;
  logic [13:0] cfg_word;
  logic [8:0] baud_mult;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [8:0] tx_exp_q [$];

  always #2.5 clk = ~clk;

  spi_uart_cmd u_spi_uart_cmd (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ferr(rx_ferr), .rx_active(rx_active),
    .cts_n(cts_n), .rts_n(rts_n), .cfg_word(cfg_word), .baud_mult(baud_mult)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic spi_xfer(input int nbits, input logic [31:0] w, output logic [15:0] rep);
    logic b;
    rep = '0;
    spi_cs_n = 1'b0;
    tick(HP);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = w[nbits-1-i];
      tick(HP);
      @(negedge clk) b = spi_miso;
      if (i < 16) rep = {rep[14:0], b};
      tick(1);
      spi_sclk = 1'b1;
      tick(HP);
      spi_sclk = 1'b0;
    end
    tick(HP);
    spi_cs_n = 1'b1;
    tick(2 * HP);
  endtask

  task automatic frame(input string req, input logic [15:0] w, input logic [15:0] exp);
    logic [15:0] rep;
    spi_xfer(16, {16'h0, w}, rep);
    check(req, {16'h0, rep}, {16'h0, exp});
  endtask

  task automatic rx_push(input logic [8:0] d, input logic fe);
    rx_data  = d;
    rx_ferr  = fe;
    rx_valid = 1'b1;
    tick(1);
    rx_valid = 1'b0;
    tick(1);
  endtask

  function automatic logic [8:0] bmult(input int c);
    return (c < 8) ? 9'(1 << c) : 9'(3 << (c - 8));
  endfunction

  // transmit scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && tx_valid && tx_ready) begin
        if (tx_exp_q.size() == 0) begin
          check("R5 unexpected tx character", {23'h0, tx_data}, 32'h0);
        end else begin
          logic [8:0] e;
          e = tx_exp_q.pop_front();
          check("R5 tx character", {23'h0, tx_data}, {23'h0, e});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rep;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    // R12 reset state
    check("R12 miso", {31'h0, spi_miso}, 32'h0);
    check("R12 rts_n", {31'h0, rts_n}, 32'h1);
    check("R12 tx_valid", {31'h0, tx_valid}, 32'h0);
    check("R12 cfg_word", {18'h0, cfg_word}, 32'h0);
    frame("R2 R4 R12 read cfg after reset", 16'h4000, 16'h4000);

    // R3 R4 R11 configuration
    frame("R3 write cfg reply", 16'hE00B, 16'h4000);
    check("R3 cfg_word", {18'h0, cfg_word}, 32'h200B);
    check("R11 baud code 11", {23'h0, baud_mult}, 32'd24);
    frame("R4 read cfg", 16'h4000, 16'h600B);
    check("R1 miso idle", {31'h0, spi_miso}, 32'h0);
    for (int c = 0; c < 16; c++) begin
      spi_xfer(16, 32'h0000E000 | c, rep);
      check("R11 baud map", {23'h0, baud_mult}, {23'h0, bmult(c)});
    end
    frame("R3 restore cfg", 16'hE00B, 16'h4000);

    // R8 R2 data reads and ordering
    cts_n = 1'b0;
    rx_push(9'h1A5, 1'b0);
    rx_push(9'h03C, 1'b1);
    rx_push(9'h0FF, 1'b0);
    frame("R8 read 1", 16'h0000, 16'hC3A5);
    frame("R8 read 2 with framing error", 16'h0000, 16'hC63C);
    frame("R8 read 3", 16'h0000, 16'hC2FF);
    frame("R2 R8 read empty", 16'h0000, 16'h4200);
    cts_n = 1'b1;
    tick(4);
    frame("R8 cts deasserted", 16'h0000, 16'h4000);
    cts_n = 1'b0;
    tick(4);

    // R9 deep FIFO
    for (int i = 0; i < 10; i++) rx_push(9'(8'h40 + i), 1'b0);
    for (int i = 0; i < 8; i++) frame("R9 deep order", 16'h0000, 16'hC240 | 16'(i));
    frame("R9 deep overflow dropped", 16'h0000, 16'h4200);

    // R9 shallow FIFO
    frame("R3 shallow cfg", 16'hC00B, 16'h4000);
    rx_push(9'h077, 1'b0);
    rx_push(9'h088, 1'b0);
    frame("R9 shallow first", 16'h0000, 16'hC277);
    frame("R9 shallow second dropped", 16'h0000, 16'h4200);

    // R8 shutdown meaning of bit 10
    frame("R3 shutdown cfg", 16'hF00B, 16'h4000);
    rx_active = 1'b1;
    rx_push(9'h012, 1'b1);
    frame("R8 shutdown activity", 16'h0000, 16'hC612);
    rx_active = 1'b0;
    rx_push(9'h034, 1'b1);
    frame("R8 shutdown hides ferr", 16'h0000, 16'hC234);
    frame("R3 normal cfg", 16'hE00B, 16'h4000);

    // R5 R6 R7 transmit
    tx_ready = 1'b0;
    tx_exp_q.push_back(9'h155);
    frame("R5 data write reply", 16'h8355, 16'h4200);
    check("R5 tx_valid", {31'h0, tx_valid}, 32'h1);
    check("R5 tx_data", {23'h0, tx_data}, 32'h155);
    check("R7 rts asserted", {31'h0, rts_n}, 32'h0);
    frame("R6 T clear while held", 16'h0000, 16'h0200);
    frame("R5 write while full", 16'h80AA, 16'h0200);
    check("R6 tx_data held", {23'h0, tx_data}, 32'h155);
    check("R7 rts released", {31'h0, rts_n}, 32'h1);
    tx_ready = 1'b1;
    tick(4);
    check("R6 drained", {31'h0, tx_valid}, 32'h0);
    frame("R6 T set after drain", 16'h0000, 16'h4200);
    frame("R5 disabled write", 16'h86CC, 16'h4200);
    check("R5 disabled no tx", {31'h0, tx_valid}, 32'h0);
    check("R7 rts independent of bit10", {31'h0, rts_n}, 32'h0);
    tx_exp_q.push_back(9'h03C);
    frame("R5 second write", 16'h803C, 16'h4200);
    tick(4);
    check("R5 scoreboard empty", tx_exp_q.size(), 32'h0);

    // R8 data write also pops
    tx_ready = 1'b0;
    rx_push(9'h1C3, 1'b0);
    frame("R8 write returns byte", 16'h8411, 16'hC3C3);
    frame("R8 popped by write", 16'h0000, 16'h4200);

    // R10 short and long frames
    spi_xfer(15, 32'h00007FFF, rep);
    check("R10 short cfg ignored", {18'h0, cfg_word}, 32'h200B);
    spi_xfer(17, 32'h0001FFFF, rep);
    check("R10 long cfg ignored", {18'h0, cfg_word}, 32'h200B);
    spi_xfer(8, 32'h00000080, rep);
    check("R10 short data write", {31'h0, tx_valid}, 32'h0);
    rx_push(9'h0A5, 1'b0);
    spi_xfer(8, 32'h0, rep);
    frame("R10 short read no pop", 16'h0000, 16'hC2A5);
    check("R1 miso idle end", {31'h0, spi_miso}, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule